// File: doc/BRIEF.md
# RGB Gamma Lookup Stage

This block sits in an LCD pixel path and applies an independent gamma curve to each colour component. It holds one table per channel (red, green, blue). Each table turns an 8-bit component into a 10-bit drive value. When the lookup is switched off, each component is widened by appending two zero bits. Either way the result comes out one clock after the pixel enters. The horizontal sync, vertical sync and data-valid strobes are delayed by the same clock, so they stay aligned with the pixels.

Software never sees the tables in a memory map. It reaches them through three small registers: a control/status word, an index word and a value word. The index word picks the target channels, sets the starting entry and can make the entry number step forward after every value write. The value word carries the entry data. Flags in the control word tell the host when the next index write and the next value write may be issued. A read request bit in the index word fetches one entry back. The host clears the enable bit, loads all three curves, and then sets the enable bit again.

Top module: `gamma_lut_stage`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0x0030 (index-ready bit 5 = 1, value-ready bit 4 = 1, fetch-ready bit 3 = 0, enable bit 0 = 0), the index word reads 0x0000 and all pixel outputs are 0.
- R2: While enable (control bit 0) is 0, each output component equals its input component shifted left by two, one clock after the input.
- R3: While enable is 1, each output component equals the entry of that channel's table addressed by the input component, one clock after the input.
- R4: The hsync, vsync and data-valid outputs equal their inputs one clock earlier, whatever the enable setting.
- R5: Index word layout: bit 12 fetch request, bit 11 step, bit 10 red, bit 9 green, bit 8 blue, bits 7:0 entry. With step set, a value write stores into every selected table at the current entry and then adds one to the entry, wrapping from 255 to 0; the entry is visible in index word bits 7:0.
- R6: With step clear, value writes keep the entry unchanged, so repeated writes overwrite the same table slot.
- R7: A value write while no channel bit is set changes no table and does not advance the entry.
- R8: Value-ready (control bit 4) is low for exactly the one clock after each value write. Index-ready (control bit 5) is low for exactly the one clock after each index write.
- R9: An index write with bit 12 set clears fetch-ready (control bit 3). One clock later fetch-ready rises and the value word reads the selected table's entry; red wins over green, and green over blue.
- R10: Control bits 7, 6, 2, 1 and 0 hold what the host writes and read back unchanged; bits 5 to 3 are status only and ignore writes.
- R11: A value write with several channel bits set stores the same value into each selected table and leaves the unselected tables untouched.
- R12: Only value word bits 9:0 are stored; bits 15:10 of a value write are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe, one register per cycle |
| host_sel | input | 2 | Register select: 0 control, 1 index, 2 value |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected register (combinational) |
| pix_in_r | input | 8 | Red input component |
| pix_in_g | input | 8 | Green input component |
| pix_in_b | input | 8 | Blue input component |
| pix_in_hs | input | 1 | Horizontal sync in |
| pix_in_vs | input | 1 | Vertical sync in |
| pix_in_de | input | 1 | Data valid in |
| pix_out_r | output | 10 | Red output component |
| pix_out_g | output | 10 | Green output component |
| pix_out_b | output | 10 | Blue output component |
| pix_out_hs | output | 1 | Horizontal sync out, one clock late |
| pix_out_vs | output | 1 | Vertical sync out, one clock late |
| pix_out_de | output | 1 | Data valid out, one clock late |

## Verification
The bench builds the stage with its default widths: an 8-bit entry index, 10-bit table values and a 16-bit register word. With these, a full 256-entry load per channel runs until the entry number wraps back to 0. The extremes 0 and 255 of the input range can be looked up in the curves. The 10-bit values leave six upper bits in every value write, which the stage must discard. Each channel gets a different curve, so a crossed channel shows up at the outputs. The bench also tests the step-off, no-select and multi-select write paths by fetching entries back through the value word.

// File: rtl/gamma_lut_pkg.sv
// Package: shared constants for the gamma lookup stage.
// Assumes three colour channels, with channel 0 red, 1 green, 2 blue.
// Bit positions are fixed because host software decodes them.
package gamma_lut_pkg;

    localparam int NUM_CH = 3;
    localparam int CH_RED = 0;
    localparam int CH_GRN = 1;
    localparam int CH_BLU = 2;

    // host register select
    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_INDEX = 2'd1,
        REG_VALUE = 2'd2
    } reg_sel_e;

    // index word fields
    localparam int IX_FETCH = 12;
    localparam int IX_STEP  = 11;
    localparam int IX_RED   = 10;
    localparam int IX_GRN   = 9;
    localparam int IX_BLU   = 8;

    // control word fields
    localparam int CT_POL     = 7;
    localparam int CT_INVOUT  = 6;
    localparam int CT_IX_RDY  = 5;
    localparam int CT_VAL_RDY = 4;
    localparam int CT_FET_RDY = 3;
    localparam int CT_HOLD2   = 2;
    localparam int CT_HOLD1   = 1;
    localparam int CT_EN      = 0;

    // bits of the control word that the host may set
    localparam logic [7:0] CT_WR_MASK = 8'hC7;

endpackage

// File: rtl/gamma_host_regs.sv
// Module: host register port for the gamma tables.
// It decodes the control, index and value words and keeps the entry
// pointer with its auto-step, and it produces the ready flags and the
// one-entry fetch. It assumes at most one host write per cycle. The
// ready flags are advisory: writes are accepted whenever they arrive.
module gamma_host_regs
    import gamma_lut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 10,
    parameter int REG_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_we,
    input  logic [1:0]                     host_sel,
    input  logic [REG_W-1:0]               host_wdata,
    output logic [REG_W-1:0]               host_rdata,
    output logic [NUM_CH-1:0]              tbl_we,
    output logic [IDX_W-1:0]               tbl_idx,
    output logic [VAL_W-1:0]               tbl_wval,
    input  logic [NUM_CH-1:0][VAL_W-1:0]   tbl_rval,
    output logic                           lut_en
);

    logic [7:0]        ctrl_q;
    logic [IDX_W-1:0]  idx_q;
    logic [NUM_CH-1:0] sel_q;
    logic              step_q;
    logic              ix_rdy_q;
    logic              val_rdy_q;
    logic              fet_rdy_q;
    logic              fet_pend_q;
    logic [VAL_W-1:0]  fet_val_q;
    logic [VAL_W-1:0]  fet_pick;
    logic              wr_ctrl;
    logic              wr_index;
    logic              wr_value;
    logic              unused_hi;

    reg_sel_e          rsel;

    assign rsel      = reg_sel_e'(host_sel);
    assign wr_ctrl   = host_we && (rsel == REG_CTRL);
    assign wr_index  = host_we && (rsel == REG_INDEX);
    assign wr_value  = host_we && (rsel == REG_VALUE);
    assign unused_hi = ^host_wdata[REG_W-1:IX_FETCH+1];

    // Purpose: the table write strobes go to every selected channel.
    assign tbl_we   = {NUM_CH{wr_value}} & sel_q;
    assign tbl_idx  = idx_q;
    assign tbl_wval = host_wdata[VAL_W-1:0];
    assign lut_en   = ctrl_q[CT_EN];

    // Purpose: choose the fetch source, red first, then green, then blue.
    always_comb begin
        fet_pick = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (sel_q[c]) fet_pick = tbl_rval[c];
        end
    end

    // Purpose: register state, pointer stepping, ready flags and fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            idx_q      <= '0;
            sel_q      <= '0;
            step_q     <= 1'b0;
            ix_rdy_q   <= 1'b1;
            val_rdy_q  <= 1'b1;
            fet_rdy_q  <= 1'b0;
            fet_pend_q <= 1'b0;
            fet_val_q  <= '0;
        end else begin
            ix_rdy_q   <= 1'b1;
            val_rdy_q  <= 1'b1;
            fet_pend_q <= 1'b0;
            if (wr_ctrl) begin
                ctrl_q <= host_wdata[7:0] & CT_WR_MASK;
            end
            if (wr_index) begin
                idx_q         <= host_wdata[IDX_W-1:0];
                step_q        <= host_wdata[IX_STEP];
                sel_q[CH_RED] <= host_wdata[IX_RED];
                sel_q[CH_GRN] <= host_wdata[IX_GRN];
                sel_q[CH_BLU] <= host_wdata[IX_BLU];
                ix_rdy_q      <= 1'b0;
                fet_rdy_q     <= 1'b0;
                fet_pend_q    <= host_wdata[IX_FETCH];
            end else if (wr_value) begin
                val_rdy_q <= 1'b0;
                if (step_q && (sel_q != '0)) begin
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (fet_pend_q) begin
                fet_val_q <= fet_pick;
                fet_rdy_q <= 1'b1;
            end
        end
    end

    // Purpose: read mux of the three host-visible words.
    always_comb begin
        host_rdata = '0;
        unique case (rsel)
            REG_CTRL: begin
                host_rdata[7:0]        = ctrl_q;
                host_rdata[CT_IX_RDY]  = ix_rdy_q;
                host_rdata[CT_VAL_RDY] = val_rdy_q;
                host_rdata[CT_FET_RDY] = fet_rdy_q;
            end
            REG_INDEX: begin
                host_rdata[IDX_W-1:0] = idx_q;
                host_rdata[IX_STEP]   = step_q;
                host_rdata[IX_RED]    = sel_q[CH_RED];
                host_rdata[IX_GRN]    = sel_q[CH_GRN];
                host_rdata[IX_BLU]    = sel_q[CH_BLU];
            end
            REG_VALUE: begin
                host_rdata[VAL_W-1:0] = fet_val_q;
            end
            default: host_rdata = '0;
        endcase
    end

    AST_VAL_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_value |=> !val_rdy_q) else $error("value-ready not dropped"); // R8
    AST_VAL_RDY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!val_rdy_q && !wr_value) |=> val_rdy_q) else $error("value-ready stuck"); // R8
    AST_IX_RDY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ix_rdy_q && !wr_index) |=> ix_rdy_q) else $error("index-ready stuck"); // R8
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_value && step_q && (sel_q != '0)) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)))
        else $error("entry pointer did not step"); // R5
    AST_PTR_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_value && (sel_q == '0)) |=> $stable(idx_q)) else $error("pointer moved without select"); // R7
    AST_FETCH_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        fet_pend_q |=> fet_rdy_q) else $error("fetch-ready did not rise"); // R9

endmodule

// File: rtl/gamma_table_bank.sv
// Module: three gamma tables, one per colour channel.
// Each table has one write port and an asynchronous read port for the
// host fetch, both at the shared entry pointer. A registered read port
// serves the pixel path. A read and a write to the same slot in one
// cycle return the old value. The tables are not reset.
module gamma_table_bank
    import gamma_lut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 10
) (
    input  logic                           clk,
    input  logic [NUM_CH-1:0]              wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [VAL_W-1:0]               wr_val,
    output logic [NUM_CH-1:0][VAL_W-1:0]   host_val,
    input  logic [NUM_CH-1:0][IDX_W-1:0]   pix_idx,
    output logic [NUM_CH-1:0][VAL_W-1:0]   pix_val
);

    localparam int DEPTH = 1 << IDX_W;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic [VAL_W-1:0] mem [DEPTH];

        // Purpose: host write and registered pixel lookup for one channel.
        always_ff @(posedge clk) begin
            if (wr_en[ch]) begin
                mem[wr_idx] <= wr_val;
            end
            pix_val[ch] <= mem[pix_idx[ch]];
        end

        assign host_val[ch] = mem[wr_idx];
    end

endmodule

// File: rtl/gamma_pixel_pipe.sv
// Module: pixel alignment stage and output select.
// It registers the widened bypass values, the strobes and the enable
// in step with the table bank's registered lookup, then picks the
// table or the bypass value. It assumes the lookup has one clock of
// latency.
module gamma_pixel_pipe
    import gamma_lut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           lut_en,
    input  logic [NUM_CH-1:0][IDX_W-1:0]   pix_in,
    input  logic [2:0]                     strb_in,
    input  logic [NUM_CH-1:0][VAL_W-1:0]   lut_val,
    output logic [NUM_CH-1:0][VAL_W-1:0]   pix_out,
    output logic [2:0]                     strb_out
);

    localparam int PAD = VAL_W - IDX_W;

    logic                          en_q;
    logic [NUM_CH-1:0][VAL_W-1:0]  byp_q;
    logic [2:0]                    strb_q;

    // Purpose: hold the enable and strobes for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            strb_q <= '0;
        end else begin
            en_q   <= lut_en;
            strb_q <= strb_in;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_byp
        // Purpose: widened bypass component, aligned with the lookup.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byp_q[ch] <= '0;
            end else begin
                byp_q[ch] <= {pix_in[ch], {PAD{1'b0}}};
            end
        end

        assign pix_out[ch] = en_q ? lut_val[ch] : byp_q[ch];

        AST_BYPASS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(lut_en)) |-> (pix_out[ch] == {$past(pix_in[ch]), {PAD{1'b0}}}))
            else $error("bypass value wrong"); // R2
    end

    assign strb_out = strb_q;

    AST_STROBE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (strb_out == $past(strb_in))) else $error("strobes misaligned"); // R4

endmodule

// File: rtl/gamma_lut_stage.sv
// Module: top of the RGB gamma lookup stage.
// It joins the host register port, the table bank and the pixel
// pipe. Each component is remapped through its channel's table, or
// widened when the lookup is off, with one clock of latency.
module gamma_lut_stage
    import gamma_lut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 10,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [1:0]       host_sel,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    input  logic [IDX_W-1:0] pix_in_r,
    input  logic [IDX_W-1:0] pix_in_g,
    input  logic [IDX_W-1:0] pix_in_b,
    input  logic             pix_in_hs,
    input  logic             pix_in_vs,
    input  logic             pix_in_de,
    output logic [VAL_W-1:0] pix_out_r,
    output logic [VAL_W-1:0] pix_out_g,
    output logic [VAL_W-1:0] pix_out_b,
    output logic             pix_out_hs,
    output logic             pix_out_vs,
    output logic             pix_out_de
);

    logic [NUM_CH-1:0]             tbl_we;
    logic [IDX_W-1:0]              tbl_idx;
    logic [VAL_W-1:0]              tbl_wval;
    logic [NUM_CH-1:0][VAL_W-1:0]  tbl_rval;
    logic [NUM_CH-1:0][VAL_W-1:0]  lut_val;
    logic [NUM_CH-1:0][IDX_W-1:0]  pix_vec;
    logic [NUM_CH-1:0][VAL_W-1:0]  out_vec;
    logic [2:0]                    strb_out;
    logic                          lut_en;

    assign pix_vec[CH_RED] = pix_in_r;
    assign pix_vec[CH_GRN] = pix_in_g;
    assign pix_vec[CH_BLU] = pix_in_b;

    gamma_host_regs #(.IDX_W(IDX_W), .VAL_W(VAL_W), .REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tbl_we     (tbl_we),
        .tbl_idx    (tbl_idx),
        .tbl_wval   (tbl_wval),
        .tbl_rval   (tbl_rval),
        .lut_en     (lut_en)
    );

    gamma_table_bank #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_bank (
        .clk      (clk),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_val   (tbl_wval),
        .host_val (tbl_rval),
        .pix_idx  (pix_vec),
        .pix_val  (lut_val)
    );

    gamma_pixel_pipe #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .lut_en   (lut_en),
        .pix_in   (pix_vec),
        .strb_in  ({pix_in_hs, pix_in_vs, pix_in_de}),
        .lut_val  (lut_val),
        .pix_out  (out_vec),
        .strb_out (strb_out)
    );

    assign pix_out_r  = out_vec[CH_RED];
    assign pix_out_g  = out_vec[CH_GRN];
    assign pix_out_b  = out_vec[CH_BLU];
    assign pix_out_hs = strb_out[2];
    assign pix_out_vs = strb_out[1];
    assign pix_out_de = strb_out[0];

endmodule

// File: tb/gamma_lut_stage_bench.sv
// Directed bench for gamma_lut_stage: one task per scenario.
module gamma_lut_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [7:0]  pix_in_r = '0, pix_in_g = '0, pix_in_b = '0;
    logic        pix_in_hs = 1'b0, pix_in_vs = 1'b0, pix_in_de = 1'b0;
    logic [9:0]  pix_out_r, pix_out_g, pix_out_b;
    logic        pix_out_hs, pix_out_vs, pix_out_de;

    int n_checks = 0;
    int n_fails  = 0;
    int model [3][256];

    always #2 clk = ~clk;

    gamma_lut_stage u_gamma_lut_stage (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_in_r(pix_in_r), .pix_in_g(pix_in_g), .pix_in_b(pix_in_b),
        .pix_in_hs(pix_in_hs), .pix_in_vs(pix_in_vs), .pix_in_de(pix_in_de),
        .pix_out_r(pix_out_r), .pix_out_g(pix_out_g), .pix_out_b(pix_out_b),
        .pix_out_hs(pix_out_hs), .pix_out_vs(pix_out_vs), .pix_out_de(pix_out_de)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    task automatic reg_write(input logic [1:0] sel, input int data);
        @(negedge clk);
        host_we    = 1'b1;
        host_sel   = sel;
        host_wdata = data[15:0];
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output int v);
        host_sel = sel;
        #1;
        v = int'(host_rdata);
    endtask

    task automatic wait_flag(input int bitpos);
        int v;
        for (int k = 0; k < 50; k++) begin
            reg_read(2'd0, v);
            if (v[bitpos]) return;
            @(negedge clk);
        end
    endtask

    task automatic fetch(input int ch, input int idx, output int v);
        int c;
        wait_flag(5);
        reg_write(2'd1, (1 << 12) | (1 << (10 - ch)) | idx);
        reg_read(2'd0, c);
        chk("R9 fetch-ready low after request", c & 8, 0);
        @(negedge clk);
        reg_read(2'd0, c);
        chk("R9 fetch-ready high", c & 8, 8);
        reg_read(2'd2, v);
    endtask

    task automatic pix_apply(input int r, input int g, input int b, input int s, input bit en);
        @(negedge clk);
        pix_in_r = r[7:0]; pix_in_g = g[7:0]; pix_in_b = b[7:0];
        {pix_in_hs, pix_in_vs, pix_in_de} = s[2:0];
        @(negedge clk);
        if (en) begin
            chk("R3 red lookup",   int'(pix_out_r), model[0][r]);
            chk("R3 green lookup", int'(pix_out_g), model[1][g]);
            chk("R3 blue lookup",  int'(pix_out_b), model[2][b]);
        end else begin
            chk("R2 red bypass",   int'(pix_out_r), r << 2);
            chk("R2 green bypass", int'(pix_out_g), g << 2);
            chk("R2 blue bypass",  int'(pix_out_b), b << 2);
        end
        chk("R4 strobes", int'({pix_out_hs, pix_out_vs, pix_out_de}), s);
    endtask

    task automatic t_reset();
        int v;
        reg_read(2'd0, v); chk("R1 control after reset", v, 'h30);
        reg_read(2'd1, v); chk("R1 index after reset", v, 0);
        chk("R1 outputs after reset", int'(pix_out_r | pix_out_g | pix_out_b), 0);
    endtask

    task automatic t_ctrl();
        int v;
        reg_write(2'd0, 'hFFFF);
        reg_read(2'd0, v); chk("R10 control readback", v, 'hF7);
        reg_write(2'd0, 'h0000);
        reg_read(2'd0, v); chk("R10 control cleared", v, 'h30);
    endtask

    task automatic t_bypass();
        pix_apply(0, 255, 128, 3'b101, 1'b0);
        pix_apply(1, 2, 3, 3'b010, 1'b0);
        pix_apply(255, 0, 77, 3'b111, 1'b0);
    endtask

    task automatic t_load();
        int v;
        reg_write(2'd0, 0);
        for (int ch = 0; ch < 3; ch++) begin
            wait_flag(5);
            reg_write(2'd1, (1 << 11) | (1 << (10 - ch)));
            if (ch == 0) begin
                reg_read(2'd0, v); chk("R8 index-ready low after index write", v & 'h20, 0);
                @(negedge clk);
                reg_read(2'd0, v); chk("R8 index-ready back", v & 'h20, 'h20);
            end
            for (int i = 0; i < 256; i++) begin
                wait_flag(4);
                reg_write(2'd2, model[ch][i]);
                if (ch == 0 && i == 0) begin
                    reg_read(2'd0, v); chk("R8 value-ready low after write", v & 'h10, 0);
                    @(negedge clk);
                    reg_read(2'd0, v); chk("R8 value-ready back", v & 'h10, 'h10);
                end
                if (ch == 1 && i == 99) begin
                    reg_read(2'd1, v); chk("R5 entry stepped", v & 'hFF, 100);
                end
            end
            reg_read(2'd1, v);
            chk("R5 entry wrapped to 0", v, (1 << 11) | (1 << (10 - ch)));
            wait_flag(5);
            reg_write(2'd1, (1 << 11) | (1 << (10 - ch)) | 'h23);
            reg_read(2'd1, v);
            chk("R5 index rewrite", v, (1 << 11) | (1 << (10 - ch)) | 'h23);
        end
        fetch(2, 255, v); chk("R9 fetch blue 255", v, model[2][255]);
        fetch(1, 0, v);   chk("R9 fetch green 0", v, model[1][0]);
        reg_write(2'd0, 1);
    endtask

    task automatic t_lookup();
        pix_apply(0, 0, 0, 3'b000, 1'b1);
        pix_apply(255, 255, 255, 3'b111, 1'b1);
        pix_apply('h23, 'h80, 'h11, 3'b001, 1'b1);
        pix_apply(200, 7, 64, 3'b100, 1'b1);
    endtask

    task automatic t_nostep();
        int v;
        wait_flag(5);
        reg_write(2'd1, (1 << 9) | 10);
        wait_flag(4); reg_write(2'd2, 'hAA);
        wait_flag(4); reg_write(2'd2, 'hBB);
        reg_read(2'd1, v); chk("R6 entry held", v & 'hFF, 10);
        model[1][10] = 'hBB;
        fetch(1, 10, v); chk("R6 last write kept", v, 'hBB);
        fetch(1, 11, v); chk("R6 next slot untouched", v, model[1][11]);
    endtask

    task automatic t_nosel();
        int v;
        wait_flag(5);
        reg_write(2'd1, (1 << 11) | 20);
        wait_flag(4); reg_write(2'd2, 'h3FF);
        reg_read(2'd1, v); chk("R7 entry not advanced", v & 'hFF, 20);
        for (int ch = 0; ch < 3; ch++) begin
            fetch(ch, 20, v); chk("R7 table unchanged", v, model[ch][20]);
        end
    endtask

    task automatic t_multi();
        int v;
        wait_flag(5);
        reg_write(2'd1, (1 << 11) | (1 << 10) | (1 << 8) | 5);
        wait_flag(4); reg_write(2'd2, 'h155);
        reg_read(2'd1, v); chk("R11 entry stepped once", v & 'hFF, 6);
        model[0][5] = 'h155;
        model[2][5] = 'h155;
        fetch(0, 5, v); chk("R11 red written", v, 'h155);
        fetch(2, 5, v); chk("R11 blue written", v, 'h155);
        fetch(1, 5, v); chk("R11 green untouched", v, model[1][5]);
    endtask

    task automatic t_trunc();
        int v;
        wait_flag(5);
        reg_write(2'd1, (1 << 11) | (1 << 10) | 7);
        wait_flag(4); reg_write(2'd2, 'hFC07);
        model[0][7] = 'h007;
        fetch(0, 7, v); chk("R12 upper bits dropped", v, 'h007);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            model[0][i] = i * 4;
            model[1][i] = 1023 - i * 4;
            model[2][i] = (i * 37 + 5) % 1024;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_bypass();
        t_load();
        t_lookup();
        t_nostep();
        t_nosel();
        t_multi();
        t_trunc();
        pix_apply(5, 10, 5, 3'b011, 1'b1);
        pix_apply(7, 11, 20, 3'b110, 1'b1);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        summary();
        $finish;
    end

endmodule